// File: doc/BRIEF.md
# Palettized VGA Pixel Output Path

This block turns a stream of packed 32-bit pixel words into 24-bit RGB for a video DAC. A bus-side DMA engine pushes words into a 32-entry asynchronous buffer using a valid/ready handshake in the bus clock domain. On the pixel clock side, each word moves into a holding register. Its four 8-bit colour indices are then issued one at a time, lowest byte first. Each index addresses three separate 256-entry by 8-bit palette RAMs, one for red, one for green and one for blue. The three read results form the RGB word.

The sync timing generator drives `pix_req` high on every active pixel. The block has no back-pressure on the output side. It answers one cycle later with `rgb` and `rgb_de` aligned to each other. The host fills the palette through a simple write port.

A DMA request with hysteresis asks for more data. It rises when the buffer is at or below the low mark and falls only once the buffer is full. When the same image goes to a second display path, `share_en` makes each write an all-or-nothing transfer into both buffers. On the input side, back-pressure works as follows:
- A word is taken only in a cycle where `wr_valid` and `wr_ready` are both high.
- `wr_ready` is low while the buffer is full.
- With sharing on, `wr_ready` is also low while the peer path is not ready.

Top module: `vga_pixel_path`

## Requirements
- R1: The input buffer holds 32 words of 32 bits. A word is accepted only when `wr_valid` and `wr_ready` are both high. `wr_ready` is low while 32 words are buffered. Accepted words leave in acceptance order, with none lost.
- R2: With `share_en` high, `wr_ready` is high only if the buffer is not full and `peer_ready` is high. `peer_valid` equals `wr_valid` while `share_en` is high and the buffer is not full, so both paths accept the same word in the same cycle. With `share_en` low, `peer_valid` stays low.
- R3: A buffered word is loaded into the holding register before any of its pixels go out. Its indices are issued as byte 0 (bits 7:0) first, then bytes 1, 2 and 3.
- R4: The next word is loaded in the same cycle that the fourth index of the current word is consumed. A continuous `pix_req` run over buffered data therefore has no gap and never sets `underflow`.
- R5: A host write with `pal_we` high stores `pal_wdata` at `pal_addr` in one palette RAM, selected by `pal_sel`: 0 is red, 1 is green, 2 is blue. Code 3 writes no RAM.
- R6: `rgb` and `rgb_de` follow `pix_req` by exactly one pixel clock. `rgb` is {red, green, blue}, with red in bits 23:16 and blue in bits 7:0.
- R7: A `pix_req` while no word is held gives `rgb` = 0 with `rgb_de` high. It also sets `underflow`, which stays set until `ufl_clr` is applied.
- R8: `dma_req` is set while 16 or fewer words are buffered. It is cleared once the buffer is full. In between, it keeps its previous value.
- R9: While `rgb_de` is low, `rgb` is 0.
- R10: After reset, `wr_ready` is high and `rgb`, `rgb_de`, `underflow` and `dma_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Write-side clock |
| bus_rst_n | input | 1 | Write-side reset, active low |
| wr_valid | input | 1 | Word offered by DMA |
| wr_ready | output | 1 | Word can be accepted |
| wr_data | input | 32 | Four packed pixel indices |
| share_en | input | 1 | Mirror writes into a peer path |
| peer_ready | input | 1 | Peer path can accept |
| peer_valid | output | 1 | Offer of the same word to the peer |
| dma_req | output | 1 | Request for more data |
| pix_clk | input | 1 | Pixel clock |
| pix_rst_n | input | 1 | Pixel-side reset, active low |
| pal_we | input | 1 | Palette write strobe |
| pal_sel | input | 2 | Palette colour select |
| pal_addr | input | 8 | Palette entry |
| pal_wdata | input | 8 | Palette value |
| pix_req | input | 1 | Active pixel requested |
| ufl_clr | input | 1 | Clear underflow flag |
| rgb | output | 24 | Colour to DAC |
| rgb_de | output | 1 | Display enable aligned with rgb |
| underflow | output | 1 | Sticky starvation flag |

## Verification
The palette is loaded with three different arithmetic functions of the index. A bad write select or a swapped colour lane then shows up as a wrong byte. A code-3 write aimed at an entry that is later displayed proves that the code is ignored.

Sixty-four words carry every index 0..255 through the path. This sweep is pulled in bursts that cross word boundaries, so byte order, the zero-gap reload and the one-cycle alignment are all checked. A fill to exactly full, followed by a drain that stops at 17 and then at 16 words, separates the two edges of the request hysteresis. A request on an empty path, and a write offered to a peer that is not ready, cover the starvation and sharing rules.

// File: rtl/vpp_pkg.sv
package vpp_pkg;
  localparam int PAL_CH = 3;
  typedef enum logic [1:0] {
    CH_RED  = 2'd0,
    CH_GRN  = 2'd1,
    CH_BLU  = 2'd2,
    CH_NONE = 2'd3
  } pal_ch_e;
endpackage

// File: rtl/vpp_sync2.sv
module vpp_sync2 #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/vpp_async_fifo.sv
module vpp_async_fifo #(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  output logic          full,
  output logic [AW:0]   wlevel,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic          empty
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0] wbin, wgray, rbin, rgray;
  logic [AW:0] rgray_ws, wgray_rs, rbin_ws, wbin_next, rbin_next;

  function automatic logic [AW:0] bin2gray(input logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [AW:0] gray2bin(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // write side
  assign wbin_next = wbin + (AW+1)'(push);

  always_ff @(posedge wclk) begin
    if (push) mem[wbin[AW-1:0]] <= wdata;
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else begin
      wbin  <= wbin_next;
      wgray <= bin2gray(wbin_next);
    end
  end

  vpp_sync2 #(.W(AW+1)) u_rsync (
    .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_ws)
  );

  assign rbin_ws = gray2bin(rgray_ws);
  assign wlevel  = wbin - rbin_ws;
  assign full    = (wlevel == (AW+1)'(DEPTH));

  // read side
  assign rbin_next = rbin + (AW+1)'(pop);

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else begin
      rbin  <= rbin_next;
      rgray <= bin2gray(rbin_next);
    end
  end

  vpp_sync2 #(.W(AW+1)) u_wsync (
    .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_rs)
  );

  assign empty = (rgray == wgray_rs);
  assign rdata = mem[rbin[AW-1:0]];

  // R1
  no_overflow_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    push |-> !full);
  // R1
  no_underrun_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    pop |-> !empty);
  // R1
  level_bound_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    wlevel <= (AW+1)'(DEPTH));
endmodule

// File: rtl/vpp_unpacker.sv
module vpp_unpacker #(
  parameter int DW = 32,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_empty,
  input  logic [DW-1:0] fifo_rdata,
  output logic          fifo_pop,
  input  logic          pix_req,
  input  logic          ufl_clr,
  output logic [PW-1:0] pix_idx,
  output logic          pix_blank,
  output logic          underflow
);
  localparam int NPIX = DW / PW;
  localparam int CW   = (NPIX > 1) ? $clog2(NPIX) : 1;

  logic [DW-1:0] hold_q;
  logic          hold_vld;
  logic [CW-1:0] sel_q;
  logic          last, consume;
  logic [PW-1:0] lanes [NPIX];

  generate
    for (genvar g = 0; g < NPIX; g++) begin : g_lane
      assign lanes[g] = hold_q[g*PW +: PW];
    end
  endgenerate

  assign last     = (sel_q == CW'(NPIX - 1));
  assign consume  = pix_req && hold_vld;
  assign fifo_pop = !fifo_empty && (!hold_vld || (consume && last));
  assign pix_idx  = lanes[sel_q];
  assign pix_blank = !hold_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q   <= '0;
      hold_vld <= 1'b0;
      sel_q    <= '0;
    end else if (fifo_pop) begin
      hold_q   <= fifo_rdata;
      hold_vld <= 1'b1;
      sel_q    <= '0;
    end else if (consume) begin
      if (last) begin
        hold_vld <= 1'b0;
        sel_q    <= '0;
      end else begin
        sel_q <= sel_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   underflow <= 1'b0;
    else if (pix_req && !hold_vld) underflow <= 1'b1;
    else if (ufl_clr)             underflow <= 1'b0;
  end

  // R7
  starve_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_req && !hold_vld) |=> underflow);
  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !last) |=> $stable(hold_q));
  // R4
  gapless_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && last && !fifo_empty) |=> hold_vld);
endmodule

// File: rtl/vpp_palette.sv
module vpp_palette
  import vpp_pkg::*;
#(
  parameter int PW = 8,
  parameter int CW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  pal_ch_e           wsel,
  input  logic [PW-1:0]     waddr,
  input  logic [CW-1:0]     wdata,
  input  logic              rd_en,
  input  logic [PW-1:0]     raddr,
  input  logic              blank_in,
  output logic [3*CW-1:0]   rgb,
  output logic              de
);
  localparam int ENTRIES = 1 << PW;

  logic [CW-1:0] rd_q [PAL_CH];
  logic          blank_q;

  generate
    for (genvar ch = 0; ch < PAL_CH; ch++) begin : g_ram
      logic [CW-1:0] mem [ENTRIES];
      always_ff @(posedge clk) begin
        if (we && (wsel == pal_ch_e'(ch))) mem[waddr] <= wdata;
        rd_q[ch] <= mem[raddr];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      de      <= 1'b0;
      blank_q <= 1'b1;
    end else begin
      de      <= rd_en;
      blank_q <= blank_in || !rd_en;
    end
  end

  assign rgb = blank_q ? '0 : {rd_q[0], rd_q[1], rd_q[2]};

  // R6
  de_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> de);
  // R6
  de_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !de);
  // R9
  dark_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !de |-> (rgb == '0));
endmodule

// File: rtl/vga_pixel_path.sv
module vga_pixel_path
  import vpp_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int FIFO_AW  = 5,
  parameter int PIX_W    = 8,
  parameter int COL_W    = 8,
  parameter int LOW_MARK = 16
) (
  input  logic               bus_clk,
  input  logic               bus_rst_n,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               share_en,
  input  logic               peer_ready,
  output logic               peer_valid,
  output logic               dma_req,
  input  logic               pix_clk,
  input  logic               pix_rst_n,
  input  logic               pal_we,
  input  logic [1:0]         pal_sel,
  input  logic [PIX_W-1:0]   pal_addr,
  input  logic [COL_W-1:0]   pal_wdata,
  input  logic               pix_req,
  input  logic               ufl_clr,
  output logic [3*COL_W-1:0] rgb,
  output logic               rgb_de,
  output logic               underflow
);
  localparam int DEPTH = 1 << FIFO_AW;

  logic               full, push, empty, pop, blank;
  logic [FIFO_AW:0]   wlevel;
  logic [DATA_W-1:0]  rdata;
  logic [PIX_W-1:0]   idx;

  assign wr_ready   = !full && (!share_en || peer_ready);
  assign peer_valid = wr_valid && share_en && !full;
  assign push       = wr_valid && wr_ready;

  vpp_async_fifo #(.DW(DATA_W), .AW(FIFO_AW)) u_fifo (
    .wclk(bus_clk), .wrst_n(bus_rst_n), .push(push), .wdata(wr_data),
    .full(full), .wlevel(wlevel),
    .rclk(pix_clk), .rrst_n(pix_rst_n), .pop(pop), .rdata(rdata), .empty(empty)
  );

  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n)                           dma_req <= 1'b0;
    else if (wlevel <= (FIFO_AW+1)'(LOW_MARK)) dma_req <= 1'b1;
    else if (full)                            dma_req <= 1'b0;
  end

  vpp_unpacker #(.DW(DATA_W), .PW(PIX_W)) u_unpack (
    .clk(pix_clk), .rst_n(pix_rst_n), .fifo_empty(empty), .fifo_rdata(rdata),
    .fifo_pop(pop), .pix_req(pix_req), .ufl_clr(ufl_clr),
    .pix_idx(idx), .pix_blank(blank), .underflow(underflow)
  );

  vpp_palette #(.PW(PIX_W), .CW(COL_W)) u_pal (
    .clk(pix_clk), .rst_n(pix_rst_n), .we(pal_we), .wsel(pal_ch_e'(pal_sel)),
    .waddr(pal_addr), .wdata(pal_wdata), .rd_en(pix_req), .raddr(idx),
    .blank_in(blank), .rgb(rgb), .de(rgb_de)
  );

  // R2
  mirror_pair_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (push && share_en) |-> (peer_valid && peer_ready));
  // R8
  dma_drop_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    full |=> !dma_req);
  // R8
  dma_raise_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (wlevel <= (FIFO_AW+1)'(LOW_MARK)) |=> dma_req);
  // R1
  full_level_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    full |-> (wlevel == (FIFO_AW+1)'(DEPTH)));
endmodule

// File: tb/tb_vga_pixel_path.sv
`timescale 1ns/1ps
module tb_vga_pixel_path;
  logic bus_clk = 0, pix_clk = 0;
  logic bus_rst_n = 0, pix_rst_n = 0;
  logic wr_valid = 0, share_en = 0, peer_ready = 0;
  logic [31:0] wr_data = 0;
  logic wr_ready, peer_valid, dma_req;
  logic pal_we = 0;
  logic [1:0] pal_sel = 0;
  logic [7:0] pal_addr = 0, pal_wdata = 0;
  logic pix_req = 0, ufl_clr = 0;
  logic [23:0] rgb;
  logic rgb_de, underflow;

  int total = 0, bad = 0;
  logic [7:0] expq [$];

  always #2   pix_clk = ~pix_clk;
  always #3.5 bus_clk = ~bus_clk;

  vga_pixel_path dut (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .share_en(share_en),
    .peer_ready(peer_ready), .peer_valid(peer_valid), .dma_req(dma_req),
    .pix_clk(pix_clk), .pix_rst_n(pix_rst_n), .pal_we(pal_we),
    .pal_sel(pal_sel), .pal_addr(pal_addr), .pal_wdata(pal_wdata),
    .pix_req(pix_req), .ufl_clr(ufl_clr), .rgb(rgb), .rgb_de(rgb_de),
    .underflow(underflow)
  );

  function automatic logic [7:0] red_of(input logic [7:0] i); return i ^ 8'h3C; endfunction
  function automatic logic [7:0] grn_of(input logic [7:0] i); return i * 8'd7 + 8'd1; endfunction
  function automatic logic [7:0] blu_of(input logic [7:0] i); return ~i; endfunction
  function automatic logic [23:0] rgb_of(input logic [7:0] i);
    return {red_of(i), grn_of(i), blu_of(i)};
  endfunction
  function automatic logic [31:0] word_of(input int k);
    return {8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pal_write(input logic [1:0] sel, input logic [7:0] a, input logic [7:0] d);
    @(negedge pix_clk);
    pal_we = 1; pal_sel = sel; pal_addr = a; pal_wdata = d;
    @(negedge pix_clk);
    pal_we = 0;
  endtask

  task automatic wr_word(input logic [31:0] d, input logic exp_peer);
    @(negedge bus_clk);
    while (!wr_ready) @(negedge bus_clk);
    wr_valid = 1; wr_data = d;
    #0.1;
    chk("R2 peer_valid", peer_valid, exp_peer);
    @(negedge bus_clk);
    wr_valid = 0;
    for (int b = 0; b < 4; b++) expq.push_back(d[8*b +: 8]);
  endtask

  task automatic bus_wait(input int n);
    repeat (n) @(negedge bus_clk);
  endtask

  // R3 R4 R6: continuous run, each sample one clock after its request
  task automatic pull(input int n);
    logic [7:0] idx;
    @(negedge pix_clk);
    pix_req = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge pix_clk);
      if (i == n - 1) pix_req = 0;
      idx = expq.pop_front();
      chk("R3 rgb", rgb, rgb_of(idx));
      chk("R6 rgb_de", rgb_de, 1);
    end
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (10) @(negedge bus_clk);
    bus_rst_n = 1; pix_rst_n = 1;
    @(negedge pix_clk);
    // R10
    chk("R10 wr_ready", wr_ready, 1);
    chk("R10 rgb", rgb, 0);
    chk("R10 rgb_de", rgb_de, 0);
    chk("R10 underflow", underflow, 0);
    bus_wait(3);
    chk("R8 dma_req empty", dma_req, 1);

    // R5: load all three palettes
    for (int i = 0; i < 256; i++) begin
      pal_write(2'd0, 8'(i), red_of(8'(i)));
      pal_write(2'd1, 8'(i), grn_of(8'(i)));
      pal_write(2'd2, 8'(i), blu_of(8'(i)));
    end
    // R5: code 3 must not touch entry 7 (checked in the sweep)
    pal_write(2'd3, 8'd7, 8'h00);

    // R7: request with nothing held
    @(negedge pix_clk); pix_req = 1;
    @(negedge pix_clk); pix_req = 0;
    chk("R7 rgb black", rgb, 0);
    chk("R7 rgb_de", rgb_de, 1);
    chk("R7 underflow set", underflow, 1);
    repeat (5) @(negedge pix_clk);
    chk("R7 sticky", underflow, 1);
    chk("R9 idle rgb", rgb, 0);
    ufl_clr = 1; @(negedge pix_clk); ufl_clr = 0;
    chk("R7 cleared", underflow, 0);

    // R2: peer not ready blocks the write
    share_en = 1; peer_ready = 0;
    @(negedge bus_clk);
    wr_valid = 1; wr_data = 32'hDEADBEEF;
    #0.1;
    chk("R2 wr_ready blocked", wr_ready, 0);
    chk("R2 offer to peer", peer_valid, 1);
    bus_wait(3);
    wr_valid = 0;
    peer_ready = 1;
    wr_word(word_of(0), 1'b1);
    share_en = 0; peer_ready = 0;
    bus_wait(20);

    // R1: fill to full
    for (int k = 1; k <= 32; k++) wr_word(word_of(k), 1'b0);
    bus_wait(10);
    chk("R1 full backpressure", wr_ready, 0);
    chk("R8 dma dropped at full", dma_req, 0);

    // R8: drain to 17 words, then 16
    pull(60);
    bus_wait(10);
    chk("R8 dma held at 17", dma_req, 0);
    pull(4);
    bus_wait(10);
    chk("R8 dma raised at 16", dma_req, 1);
    chk("R1 ready after drain", wr_ready, 1);

    pull(68);
    chk("R4 no gap first batch", underflow, 0);

    for (int k = 33; k < 64; k++) wr_word(word_of(k), 1'b0);
    bus_wait(20);
    pull(124);
    chk("R4 no gap second batch", underflow, 0);
    chk("R1 all words delivered", expq.size(), 0);

    repeat (3) @(negedge pix_clk);
    // R9
    chk("R9 rgb dark", rgb, 0);
    chk("R9 rgb_de low", rgb_de, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule